// File: doc/BRIEF.md
# Prescaled Coincidence Trigger Unit

The unit watches six discriminated detector lines: a cosmic line, a periodic clock-trigger line and four counter signals called S0, S1, S2M and CER. It turns each rising edge into a gate window of programmable length. From these windows it builds nine trigger channels:

- two single-line channels, one for the clock trigger and one for the cosmic line;
- six pairwise coincidences;
- one anti-coincidence, S2M with no CER window open.

Each channel counts its own occurrences, and a logarithmic prescaler on each channel lets only a chosen fraction of them through.

Any channel that passes raises a single-cycle event trigger. A software-issued trigger line does the same. In the same cycle the unit latches a 17-bit pattern word, with a valid strobe. The low six bits of that word hold the raw line states at the moment of the trigger. The upper bits name the channels that passed. A busy line from the readout side holds off further triggers and keeps the pattern word intact until readout has finished.

Configuration arrives over a simple write port. Addresses 0 to 8 take each channel's 4-bit prescale code. Address 9 takes the gate width, counted in clock cycles; at 200 MHz one count is 5 ns.

Top module: `trig_coinc_unit`

## Requirements
- R1: After reset `evt_trig`, `pat_valid` and `pat_word` are zero, every channel is disabled (code 0) and the gate width is 14 cycles.
- R2: When a trigger is issued, `pat_word[5:0]` records the raw line states (bit0 cosmic, bit1 clock trigger, bit2 S0, bit3 S1, bit4 S2M, bit5 CER), even for lines whose channel is disabled.
- R3: A rising edge on a line opens a window of G cycles (G = gate width). A pair coincidence occurs when the rising edges of its two lines are at most G-1 cycles apart. Edges that are G or more cycles apart give no coincidence.
- R4: The anti-coincidence channel occurs when an S2M window is open and no CER window is open. Each channel counts once per rising edge of its condition.
- R5: Passed channels set these pattern bits: clock 16, cosmic 15, S0·S1 13, S0·S2M 12, S0·CER 11, S1·S2M 10, S1·CER 9, S2M·CER 8, S2M·!CER 6. Bit 7 always reads zero. Every trigger shows at least one cause bit in [16:6].
- R6: Prescale code 0 blocks a channel. Code 1 passes every occurrence. Code n (2..15) passes one occurrence in 2^(n-1), and the first pass is the 2^(n-1)th occurrence after the code was written.
- R7: Writing a channel's code restarts that channel's occurrence count, even when the same code is written again.
- R8: A software trigger pulse sampled while not busy gives `evt_trig` and bit 14 of `pat_word` on the next cycle.
- R9: While `busy` is high, no trigger is issued in the following cycle and `pat_word` keeps its value. Prescalers keep counting during this time.
- R10: A line pulse on a single-line channel with code 1 gives `evt_trig` three clock edges after it is driven, one cycle wide. `pat_valid` is high in exactly the trigger cycles, and `pat_word` changes only then.
- R11: A write with `cfg_addr` 0..8 sets channel `cfg_addr`'s code from `cfg_data[3:0]`. Channel order: 0 clock, 1 cosmic, 2 S2M·!CER, 3 S0·S1, 4 S0·S2M, 5 S0·CER, 6 S1·S2M, 7 S1·CER, 8 S2M·CER. Address 9 sets the gate width from `cfg_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_in | input | 6 | Raw trigger lines, bit order as in R2 |
| sw_trig | input | 1 | Software trigger request |
| busy | input | 1 | Readout busy, holds off triggers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address (0..8 prescale codes, 9 gate width) |
| cfg_data | input | 8 | Configuration write data |
| evt_trig | output | 1 | Event trigger pulse |
| pat_valid | output | 1 | Pattern word strobe |
| pat_word | output | 17 | Latched trigger pattern word |

## Verification
The assertions check the following on every cycle:

- busy suppresses triggers and freezes the pattern word;
- a software request always produces a trigger with bit 14;
- the pattern word changes only in trigger cycles, and only together with its strobe;
- bit 7 stays clear, and every trigger carries a cause bit.

Some behaviours can only be shown by the bench's scenarios:

- the window arithmetic at G-1 against G cycles of separation;
- the anti-coincidence ordering;
- the prescale ratios and the restart on a code write;
- the raw-bit capture for disabled lines;
- the exact three-edge latency.

// File: rtl/trig_cu_pkg.sv
package trig_cu_pkg;
  localparam int NUM_IN  = 6;
  localparam int NUM_CH  = 9;
  localparam int CODE_W  = 4;
  localparam int PAT_W   = 17;
  // largest division is 2^(2^CODE_W - 2)
  localparam int PCNT_W  = (1 << CODE_W) - 2;

  // raw line indices
  localparam int LN_COSMIC = 0;
  localparam int LN_CLK    = 1;
  localparam int LN_S0     = 2;
  localparam int LN_S1     = 3;
  localparam int LN_S2M    = 4;
  localparam int LN_CER    = 5;

  // place passed channels and the software request into pattern positions
  function automatic logic [PAT_W-1:0] cause_bits(input logic [NUM_CH-1:0] pass,
                                                  input logic sw);
    logic [PAT_W-1:0] w;
    w     = '0;
    w[16] = pass[0];
    w[15] = pass[1];
    w[6]  = pass[2];
    w[13] = pass[3];
    w[12] = pass[4];
    w[11] = pass[5];
    w[10] = pass[6];
    w[9]  = pass[7];
    w[8]  = pass[8];
    w[14] = sw;
    return w;
  endfunction
endpackage

// File: rtl/trig_cu_gate.sv
module trig_cu_gate #(
  parameter int GATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [GATE_W-1:0] width,
  output logic              raw_o,
  output logic              gate_o
);
  logic              din_q, din_qq;
  logic [GATE_W-1:0] cnt_q, cnt_d;
  logic              rise;

  always_comb begin
    rise  = din_q & ~din_qq;
    cnt_d = cnt_q;
    if (rise)
      cnt_d = width;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q  <= 1'b0;
      din_qq <= 1'b0;
      cnt_q  <= '0;
    end else begin
      din_q  <= din;
      din_qq <= din_q;
      cnt_q  <= cnt_d;
    end
  end

  assign raw_o  = din_q;
  assign gate_o = (cnt_q != '0);
endmodule

// File: rtl/trig_cu_coinc.sv
module trig_cu_coinc
  import trig_cu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] gate,
  output logic [NUM_CH-1:0] occ
);
  logic [NUM_CH-1:0] cond, cond_q;

  always_comb begin
    cond[0] = gate[LN_CLK];
    cond[1] = gate[LN_COSMIC];
    cond[2] = gate[LN_S2M] & ~gate[LN_CER];
    cond[3] = gate[LN_S0]  & gate[LN_S1];
    cond[4] = gate[LN_S0]  & gate[LN_S2M];
    cond[5] = gate[LN_S0]  & gate[LN_CER];
    cond[6] = gate[LN_S1]  & gate[LN_S2M];
    cond[7] = gate[LN_S1]  & gate[LN_CER];
    cond[8] = gate[LN_S2M] & gate[LN_CER];
    occ     = cond & ~cond_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cond_q <= '0;
    else
      cond_q <= cond;
  end
endmodule

// File: rtl/trig_cu_prescale.sv
module trig_cu_prescale #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_we,
  input  logic [CODE_W-1:0] code_in,
  input  logic              occ,
  output logic              pass_o
);
  logic [CODE_W-1:0] code_q, code_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, last;
  logic              on;

  always_comb begin
    on     = (code_q != '0);
    last   = ~({CNT_W{1'b1}} << (code_q - 1'b1));
    pass_o = occ & on & (cnt_q == last);
    code_d = code_q;
    cnt_d  = cnt_q;
    if (code_we) begin
      code_d = code_in;
      cnt_d  = '0;
    end else if (occ && on) begin
      cnt_d = (cnt_q == last) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cnt_q  <= '0;
    end else begin
      code_q <= code_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/trig_coinc_unit.sv
module trig_coinc_unit
  import trig_cu_pkg::*;
#(
  parameter int GATE_W   = 8,
  parameter int GATE_RST = 14,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_IN-1:0]   det_in,
  input  logic                sw_trig,
  input  logic                busy,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_data,
  output logic                evt_trig,
  output logic                pat_valid,
  output logic [PAT_W-1:0]    pat_word
);
  localparam logic [ADDR_W-1:0] GATE_ADDR = ADDR_W'(NUM_CH);

  logic [1:0]              rst_pipe;
  logic                    rst_s;
  logic [GATE_W-1:0]       gw_q, gw_d;
  logic [NUM_IN-1:0]       raw, gate;
  logic [NUM_CH-1:0]       occ, pass, ps_we;
  logic                    fire, trig_d, trig_q, valid_q;
  logic [PAT_W-1:0]        pat_d, pat_q;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  always_comb begin
    gw_d = gw_q;
    if (cfg_we && cfg_addr == GATE_ADDR)
      gw_d = cfg_data[GATE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)
      gw_q <= GATE_W'(GATE_RST);
    else
      gw_q <= gw_d;
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_line
    trig_cu_gate #(.GATE_W(GATE_W)) u_gate (
      .clk   (clk),
      .rst_n (rst_s),
      .din   (det_in[i]),
      .width (gw_q),
      .raw_o (raw[i]),
      .gate_o(gate[i])
    );
  end

  trig_cu_coinc u_coinc (
    .clk  (clk),
    .rst_n(rst_s),
    .gate (gate),
    .occ  (occ)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign ps_we[c] = cfg_we && (cfg_addr == ADDR_W'(c));
    trig_cu_prescale #(.CODE_W(CODE_W), .CNT_W(PCNT_W)) u_ps (
      .clk    (clk),
      .rst_n  (rst_s),
      .code_we(ps_we[c]),
      .code_in(cfg_data[CODE_W-1:0]),
      .occ    (occ[c]),
      .pass_o (pass[c])
    );
  end

  always_comb begin
    fire   = (|pass) | sw_trig;
    trig_d = fire & ~busy;
    pat_d  = pat_q;
    if (trig_d)
      pat_d = cause_bits(pass, sw_trig) | PAT_W'(raw);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      trig_q  <= 1'b0;
      valid_q <= 1'b0;
      pat_q   <= '0;
    end else begin
      trig_q  <= trig_d;
      valid_q <= trig_d;
      pat_q   <= pat_d;
    end
  end

  assign evt_trig  = trig_q;
  assign pat_valid = valid_q;
  assign pat_word  = pat_q;
endmodule

// File: rtl/trig_cu_chk.sv
module trig_cu_chk #(
  parameter int PAT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             sw_trig,
  input logic             evt_trig,
  input logic             pat_valid,
  input logic [PAT_W-1:0] pat_word
);
  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !evt_trig);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pat_word));
  // R8
  sw_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_trig && !busy) |=> (evt_trig && pat_word[14]));
  // R10
  pat_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pat_word) |-> evt_trig);
  // R10
  valid_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_valid |-> evt_trig);
  // R5
  bit7_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_word[7]);
  // R5
  cause_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_trig |-> (pat_word[16:6] != '0));
endmodule

bind trig_coinc_unit trig_cu_chk #(.PAT_W(17)) u_chk (
  .clk      (clk),
  .rst_n    (rst_s),
  .busy     (busy),
  .sw_trig  (sw_trig),
  .evt_trig (evt_trig),
  .pat_valid(pat_valid),
  .pat_word (pat_word)
);

// File: tb/sim_trig_coinc_unit.sv
module sim_trig_coinc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  det_in;
  logic        sw_trig, busy, cfg_we;
  logic [3:0]  cfg_addr;
  logic [7:0]  cfg_data;
  logic        evt_trig, pat_valid;
  logic [16:0] pat_word;

  int errors = 0;
  int checks = 0;
  int trig_cnt = 0;
  logic [16:0] log_pat [0:255];
  bit done = 0;

  always #10 clk = ~clk;

  trig_coinc_unit u0 (
    .clk(clk), .rst_n(rst_n), .det_in(det_in), .sw_trig(sw_trig), .busy(busy),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .evt_trig(evt_trig), .pat_valid(pat_valid), .pat_word(pat_word)
  );

  always @(negedge clk) begin
    if (rst_n && evt_trig) begin
      log_pat[trig_cnt[7:0]] = pat_word;
      trig_cnt = trig_cnt + 1;
    end
  end

  // vector fields: line a, line b, separation, trigger count, cause bits
  localparam logic [36:0] VEC [0:11] = '{
    {6'h04, 6'h08, 4'd2, 4'd1, 17'h02000},
    {6'h04, 6'h08, 4'd4, 4'd0, 17'h00000},
    {6'h04, 6'h08, 4'd3, 4'd1, 17'h02000},
    {6'h10, 6'h20, 4'd1, 4'd2, 17'h00140},
    {6'h30, 6'h00, 4'd1, 4'd1, 17'h00100},
    {6'h01, 6'h00, 4'd1, 4'd1, 17'h08000},
    {6'h02, 6'h00, 4'd1, 4'd1, 17'h10000},
    {6'h28, 6'h00, 4'd1, 4'd1, 17'h00200},
    {6'h14, 6'h00, 4'd1, 4'd1, 17'h01040},
    {6'h08, 6'h10, 4'd1, 4'd1, 17'h00440},
    {6'h24, 6'h00, 4'd1, 4'd1, 17'h00800},
    {6'h04, 6'h04, 4'd5, 4'd0, 17'h00000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pair(input logic [5:0] a, input logic [5:0] b, input int dly);
    @(negedge clk);
    det_in = a;
    @(negedge clk);
    det_in = '0;
    repeat (dly - 1) @(negedge clk);
    det_in = b;
    @(negedge clk);
    det_in = '0;
    repeat (20) @(negedge clk);
  endtask

  task automatic cosmic_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      det_in = 6'h01;
      @(negedge clk);
      det_in = '0;
      repeat (10) @(negedge clk);
    end
  endtask

  function automatic logic [16:0] or_log(input int from, input int upto);
    logic [16:0] acc;
    acc = '0;
    for (int k = from; k < upto; k++) acc |= log_pat[k[7:0]];
    return acc;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c0;
    rst_n = 1'b0; det_in = '0; sw_trig = 1'b0; busy = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 evt_trig in reset", 32'(evt_trig), 0);
    chk("R1 pat_valid in reset", 32'(pat_valid), 0);
    chk("R1 pat_word in reset", 32'(pat_word), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: channels disabled by default
    c0 = trig_cnt;
    pair(6'h01, 6'h02, 2);
    chk("R1 default disabled", trig_cnt - c0, 0);

    // R1 / R3: default window of 14 cycles, channel 3 enabled (R11 address 3)
    cfg_write(4'd3, 8'd1);
    c0 = trig_cnt;
    pair(6'h04, 6'h08, 13);
    chk("R3 default gate, 13 apart", trig_cnt - c0, 1);
    c0 = trig_cnt;
    pair(6'h04, 6'h08, 14);
    chk("R3 default gate, 14 apart", trig_cnt - c0, 0);

    // R11: gate width 4, all channels at code 1
    cfg_write(4'd9, 8'd4);
    for (int i = 0; i < 9; i++) cfg_write(4'(i), 8'd1);
    for (int v = 0; v < 12; v++) begin
      c0 = trig_cnt;
      pair(VEC[v][36:31], VEC[v][30:25], int'(VEC[v][24:21]));
      chk($sformatf("R3 R4 vector %0d count", v), trig_cnt - c0, 32'(VEC[v][20:17]));
      chk($sformatf("R5 vector %0d cause bits", v), 32'(or_log(c0, trig_cnt) & 17'h1FFC0),
          32'(VEC[v][16:0]));
    end

    // R10: latency and width
    @(negedge clk);
    det_in = 6'h01;
    @(negedge clk);
    det_in = '0;
    @(negedge clk);
    chk("R10 no trigger after two edges", 32'(evt_trig), 0);
    @(negedge clk);
    chk("R10 trigger after three edges", 32'(evt_trig), 1);
    chk("R10 strobe with trigger", 32'(pat_valid), 1);
    chk("R10 pattern cosmic", 32'(pat_word), 32'h08000);
    @(negedge clk);
    chk("R10 one cycle wide", 32'(evt_trig), 0);
    repeat (20) @(negedge clk);

    // R2: raw bits recorded for disabled lines
    for (int i = 0; i < 9; i++) cfg_write(4'(i), (i == 1) ? 8'd1 : 8'd0);
    c0 = trig_cnt;
    @(negedge clk);
    det_in = 6'h25;
    repeat (5) @(negedge clk);
    det_in = '0;
    repeat (20) @(negedge clk);
    chk("R2 single trigger", trig_cnt - c0, 1);
    chk("R2 raw bits", 32'(log_pat[c0[7:0]]), 32'h08025);

    // R8: software trigger
    @(negedge clk);
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
    chk("R8 sw trigger", 32'(evt_trig), 1);
    chk("R8 sw pattern", 32'(pat_word), 32'h04000);

    // R9: busy blocks
    repeat (3) @(negedge clk);
    busy = 1'b1;
    c0 = trig_cnt;
    @(negedge clk);
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
    cosmic_pulses(2);
    chk("R9 busy no trigger", trig_cnt - c0, 0);
    chk("R9 busy pattern held", 32'(pat_word), 32'h04000);
    busy = 1'b0;

    // R6: code 3 passes one in four
    cfg_write(4'd1, 8'd3);
    c0 = trig_cnt;
    cosmic_pulses(3);
    chk("R6 code3 after 3", trig_cnt - c0, 0);
    cosmic_pulses(1);
    chk("R6 code3 after 4", trig_cnt - c0, 1);
    cosmic_pulses(4);
    chk("R6 code3 after 8", trig_cnt - c0, 2);

    // R6: code 5 passes one in sixteen
    cfg_write(4'd1, 8'd5);
    c0 = trig_cnt;
    cosmic_pulses(15);
    chk("R6 code5 after 15", trig_cnt - c0, 0);
    cosmic_pulses(1);
    chk("R6 code5 after 16", trig_cnt - c0, 1);

    // R7: rewrite restarts count
    cfg_write(4'd1, 8'd3);
    c0 = trig_cnt;
    cosmic_pulses(2);
    cfg_write(4'd1, 8'd3);
    cosmic_pulses(3);
    chk("R7 restart after rewrite", trig_cnt - c0, 0);
    cosmic_pulses(1);
    chk("R7 pass on fourth after rewrite", trig_cnt - c0, 1);

    // R6: code 0 blocks
    cfg_write(4'd1, 8'd0);
    c0 = trig_cnt;
    cosmic_pulses(4);
    chk("R6 code0 blocked", trig_cnt - c0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule